// File: doc/BRIEF.md
# Secondary Interrupt Controller with Pass-Through

This block gathers thirty-two level-sensitive interrupt requests from peripherals. It combines them through a software-controlled enable mask into one summary request for an upstream primary controller. Ten lines in the band 21 to 30 can also be switched, one by one, to bypass the mask. Each such line then drives its own output, with the same index, straight into a dedicated input of the primary controller. The summary request is carried on output 31. Outputs 0 to 20 are never driven.

Software reaches the block over a simple synchronous register bus. The bus has a word address covering a 4 KB window (1024 words), a write strobe, write data and registered read data. The enable mask and the pass-through enables are changed only through write-one-to-set and write-one-to-clear registers. A pair of soft-interrupt registers works on mask bit 0 alone. All state is clocked. Reset clears the mask and the pass-through enables, which drives every output low.

Top module: `sic_passthru_ctrl`

## Requirements
- R1: Word 1 reads the raw level register, which holds the value of `irq_in` captured at the previous clock edge.
- R2: `irq_out[31]` is high exactly when some bit of (raw levels AND enable mask) is set.
- R3: Word 0 reads the masked status, raw levels AND enable mask.
- R4: Writing word 2 sets every mask bit that is 1 in the write data and leaves the other bits alone. Reading word 2 returns the mask.
- R5: Writing word 3 clears every mask bit that is 1 in the write data and leaves the other bits alone.
- R6: Reading word 4 returns raw level bit 0 in bit 0, with all other bits zero. A nonzero write to word 4 sets mask bit 0. A nonzero write to word 5 clears mask bit 0. A zero write to either word changes nothing.
- R7: For each line i from 21 to 30 whose pass-through enable is set, `irq_out[i]` equals raw level bit i whatever the mask holds. While the enable is clear, `irq_out[i]` is low.
- R8: Writing word 8 sets pass-through enables only in bits 21 to 30. All other write-data bits are ignored. Reading word 8 returns the pass-through enable register.
- R9: Writing word 9 clears every pass-through enable bit that is 1 in the write data.
- R10: `irq_out[20:0]` is always zero, whatever the inputs are.
- R11: Reads of words other than 0, 1, 2, 4 and 8 return zero. Writes to words other than 2, 3, 4, 5, 8 and 9 change nothing.
- R12: Reset (`rst_n` low, asynchronous) clears the mask, the pass-through enables, the raw levels and the read data. All outputs then stay low until software enables a line.
- R13: `irq_out` changes one clock edge after the input change or register write that causes it, never in the same cycle. `bus_rdata` presents, one edge after the address, the register value from before any write in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_word_addr | input | 10 | Word address inside the 4 KB window (byte address divided by 4) |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data of the word addressed in the previous cycle |
| irq_in | input | 32 | Level-sensitive interrupt requests |
| irq_out | output | 32 | Pass-through lines 21 to 30 and the combined request on line 31 |

## Verification
Every result of this block is due exactly one rising edge after its cause. The raw levels, the combined line 31 and the pass-through lines follow `irq_in` and register writes after one edge. Read data follows the address after one edge and shows the state from before that cycle's write. The bench drives each vector on a falling edge and compares on the next falling edge, so each check lands half a cycle after the single edge the result needs. A separate directed test samples the outputs in the same half cycle as a new stimulus, to show that nothing passes through combinationally.

// File: rtl/sic_pkg.sv
package sic_pkg;

    // Word offsets software relies on (byte offset divided by four)
    localparam int unsigned WOFF_STATUS   = 0;
    localparam int unsigned WOFF_RAW      = 1;
    localparam int unsigned WOFF_EN_SET   = 2;
    localparam int unsigned WOFF_EN_CLR   = 3;
    localparam int unsigned WOFF_SOFT_SET = 4;
    localparam int unsigned WOFF_SOFT_CLR = 5;
    localparam int unsigned WOFF_PT_SET   = 8;
    localparam int unsigned WOFF_PT_CLR   = 9;

    // Decoded register selection
    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_RAW,
        SEL_EN_SET,
        SEL_EN_CLR,
        SEL_SOFT_SET,
        SEL_SOFT_CLR,
        SEL_PT_SET,
        SEL_PT_CLR
    } reg_sel_e;

endpackage

// File: rtl/sic_addr_dec.sv
module sic_addr_dec
    import sic_pkg::*;
#(
    parameter int WORD_AW = 10
) (
    input  logic [WORD_AW-1:0] word_addr,
    output reg_sel_e           sel
);

    always_comb begin
        sel = SEL_NONE;
        case (int'(word_addr))
            WOFF_STATUS:   sel = SEL_STATUS;
            WOFF_RAW:      sel = SEL_RAW;
            WOFF_EN_SET:   sel = SEL_EN_SET;
            WOFF_EN_CLR:   sel = SEL_EN_CLR;
            WOFF_SOFT_SET: sel = SEL_SOFT_SET;
            WOFF_SOFT_CLR: sel = SEL_SOFT_CLR;
            WOFF_PT_SET:   sel = SEL_PT_SET;
            WOFF_PT_CLR:   sel = SEL_PT_CLR;
            default:       sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/sic_wr_update.sv
module sic_wr_update
    import sic_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int PT_LO   = 21,
    parameter int PT_HI   = 30
) (
    input  reg_sel_e           sel,
    input  logic               we,
    input  logic [N_LINES-1:0] wdata,
    input  logic [N_LINES-1:0] mask_q,
    input  logic [N_LINES-1:0] pten_q,
    output logic [N_LINES-1:0] mask_d,
    output logic [N_LINES-1:0] pten_d
);

    function automatic logic [N_LINES-1:0] band_f();
        logic [N_LINES-1:0] b;
        b = '0;
        for (int i = PT_LO; i <= PT_HI; i++) begin
            b[i] = 1'b1;
        end
        return b;
    endfunction

    localparam logic [N_LINES-1:0] PT_BAND = band_f();

    logic wdata_nz;
    assign wdata_nz = |wdata;

    always_comb begin
        mask_d = mask_q;
        pten_d = pten_q;
        if (we) begin
            case (sel)
                SEL_EN_SET:   mask_d = mask_q | wdata;
                SEL_EN_CLR:   mask_d = mask_q & ~wdata;
                SEL_SOFT_SET: mask_d[0] = mask_q[0] | wdata_nz;
                SEL_SOFT_CLR: mask_d[0] = mask_q[0] & ~wdata_nz;
                SEL_PT_SET:   pten_d = pten_q | (wdata & PT_BAND);
                SEL_PT_CLR:   pten_d = pten_q & ~wdata;
                default: begin
                    mask_d = mask_q;
                    pten_d = pten_q;
                end
            endcase
        end
    end

endmodule

// File: rtl/sic_out_gen.sv
module sic_out_gen #(
    parameter int N_LINES   = 32,
    parameter int PT_LO     = 21,
    parameter int PT_HI     = 30,
    parameter int COMB_LINE = 31,
    localparam int PT_W     = PT_HI - PT_LO + 1
) (
    input  logic [N_LINES-1:0] raw,
    input  logic [N_LINES-1:0] mask,
    input  logic [PT_W-1:0]    pten_band,
    output logic [N_LINES-1:0] out
);

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        if (i == COMB_LINE) begin : g_comb
            assign out[i] = |(raw & mask);
        end else if (i >= PT_LO && i <= PT_HI) begin : g_pass
            assign out[i] = pten_band[i-PT_LO] & raw[i];
        end else begin : g_idle
            assign out[i] = 1'b0;
        end
    end

endmodule

// File: rtl/sic_rd_mux.sv
module sic_rd_mux
    import sic_pkg::*;
#(
    parameter int N_LINES = 32
) (
    input  reg_sel_e           sel,
    input  logic [N_LINES-1:0] raw,
    input  logic [N_LINES-1:0] mask,
    input  logic [N_LINES-1:0] pten,
    output logic [N_LINES-1:0] rdata
);

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_STATUS:   rdata = raw & mask;
            SEL_RAW:      rdata = raw;
            SEL_EN_SET:   rdata = mask;
            SEL_SOFT_SET: rdata[0] = raw[0];
            SEL_PT_SET:   rdata = pten;
            default:      rdata = '0;
        endcase
    end

endmodule

// File: rtl/sic_passthru_ctrl.sv
module sic_passthru_ctrl
    import sic_pkg::*;
#(
    parameter int N_LINES      = 32,
    parameter int WINDOW_BYTES = 4096,
    parameter int PT_LO        = 21,
    parameter int PT_HI        = 30,
    parameter int COMB_LINE    = 31,
    localparam int WORD_AW     = $clog2(WINDOW_BYTES / 4)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_AW-1:0] bus_word_addr,
    input  logic               bus_we,
    input  logic [N_LINES-1:0] bus_wdata,
    output logic [N_LINES-1:0] bus_rdata,
    input  logic [N_LINES-1:0] irq_in,
    output logic [N_LINES-1:0] irq_out
);

    typedef struct packed {
        logic [N_LINES-1:0] raw;
        logic [N_LINES-1:0] mask;
        logic [N_LINES-1:0] pten;
        logic [N_LINES-1:0] out;
        logic [N_LINES-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    logic [N_LINES-1:0] raw_q, mask_q, pten_q;
    logic [N_LINES-1:0] mask_nx, pten_nx, out_nx, rd_nx;
    reg_sel_e           sel;

    assign raw_q  = st_q.raw;
    assign mask_q = st_q.mask;
    assign pten_q = st_q.pten;

    sic_addr_dec #(
        .WORD_AW (WORD_AW)
    ) u_dec (
        .word_addr (bus_word_addr),
        .sel       (sel)
    );

    sic_wr_update #(
        .N_LINES (N_LINES),
        .PT_LO   (PT_LO),
        .PT_HI   (PT_HI)
    ) u_wr (
        .sel    (sel),
        .we     (bus_we),
        .wdata  (bus_wdata),
        .mask_q (mask_q),
        .pten_q (pten_q),
        .mask_d (mask_nx),
        .pten_d (pten_nx)
    );

    // Outputs are formed from the next-state values so they land on the same edge
    sic_out_gen #(
        .N_LINES   (N_LINES),
        .PT_LO     (PT_LO),
        .PT_HI     (PT_HI),
        .COMB_LINE (COMB_LINE)
    ) u_out (
        .raw       (irq_in),
        .mask      (mask_nx),
        .pten_band (pten_nx[PT_HI:PT_LO]),
        .out       (out_nx)
    );

    // Reads see the state held before this cycle's write
    sic_rd_mux #(
        .N_LINES (N_LINES)
    ) u_rd (
        .sel   (sel),
        .raw   (raw_q),
        .mask  (mask_q),
        .pten  (pten_q),
        .rdata (rd_nx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.raw   = irq_in;
        st_d.mask  = mask_nx;
        st_d.pten  = pten_nx;
        st_d.out   = out_nx;
        st_d.rdata = rd_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_out   = st_q.out;
    assign bus_rdata = st_q.rdata;

endmodule

// File: rtl/sic_chk.sv
module sic_chk #(
    parameter int N_LINES   = 32,
    parameter int WORD_AW   = 10,
    parameter int PT_LO     = 21,
    parameter int PT_HI     = 30,
    parameter int COMB_LINE = 31
) (
    input logic               clk,
    input logic               rst_n,
    input logic [WORD_AW-1:0] bus_word_addr,
    input logic               bus_we,
    input logic [N_LINES-1:0] bus_wdata,
    input logic [N_LINES-1:0] irq_in,
    input logic [N_LINES-1:0] irq_out,
    input logic [N_LINES-1:0] raw_q,
    input logic [N_LINES-1:0] mask_q,
    input logic [N_LINES-1:0] pten_q
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    logic [N_LINES-1:0] band;
    always_comb begin
        band = '0;
        for (int i = PT_LO; i <= PT_HI; i++) begin
            band[i] = 1'b1;
        end
    end

    // R1
    raw_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> raw_q == $past(irq_in));

    // R2
    comb_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out[COMB_LINE] == |(raw_q & mask_q));

    // R7
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out[PT_HI:PT_LO] == (raw_q[PT_HI:PT_LO] & pten_q[PT_HI:PT_LO]));

    // R10
    quiet_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out[PT_LO-1:0] == '0);

    // R4
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(bus_we && bus_word_addr == WORD_AW'(2)))
            |-> (mask_q & $past(bus_wdata)) == $past(bus_wdata));

    // R5
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(bus_we && bus_word_addr == WORD_AW'(3)))
            |-> (mask_q & $past(bus_wdata)) == '0);

    // R8
    pt_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pten_q & ~band) == '0);

endmodule

bind sic_passthru_ctrl sic_chk #(
    .N_LINES   (N_LINES),
    .WORD_AW   (WORD_AW),
    .PT_LO     (PT_LO),
    .PT_HI     (PT_HI),
    .COMB_LINE (COMB_LINE)
) u_sic_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_word_addr (bus_word_addr),
    .bus_we        (bus_we),
    .bus_wdata     (bus_wdata),
    .irq_in        (irq_in),
    .irq_out       (irq_out),
    .raw_q         (raw_q),
    .mask_q        (mask_q),
    .pten_q        (pten_q)
);

// File: tb/test_sic_passthru_ctrl.sv
module test_sic_passthru_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  bus_word_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in = '0;
    logic [31:0] irq_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sic_passthru_ctrl i_sic_passthru_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_word_addr (bus_word_addr),
        .bus_we        (bus_we),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .irq_in        (irq_in),
        .irq_out       (irq_out)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // {req, we, word, wdata, irq_in, expected rdata, expected irq_out}
    localparam int NV = 16;
    localparam logic [142:0] VEC [NV] = '{
        {4'd1,  1'b0, 10'd1,   32'h0000_0000, 32'h0000_00F0, 32'h0000_0000, 32'h0000_0000}, // R1
        {4'd1,  1'b0, 10'd1,   32'h0000_0000, 32'h0000_00F0, 32'h0000_00F0, 32'h0000_0000}, // R1
        {4'd4,  1'b1, 10'd2,   32'h0000_0030, 32'h0000_00F0, 32'h0000_0000, 32'h8000_0000}, // R4
        {4'd3,  1'b0, 10'd0,   32'h0000_0000, 32'h0000_00F0, 32'h0000_0030, 32'h8000_0000}, // R3
        {4'd4,  1'b0, 10'd2,   32'h0000_0000, 32'h0000_00F0, 32'h0000_0030, 32'h8000_0000}, // R4
        {4'd5,  1'b1, 10'd3,   32'h0000_0010, 32'h0000_00F0, 32'h0000_0000, 32'h8000_0000}, // R5
        {4'd2,  1'b0, 10'd0,   32'h0000_0000, 32'h0000_000F, 32'h0000_0020, 32'h0000_0000}, // R2
        {4'd6,  1'b1, 10'd4,   32'h0000_0005, 32'h0000_0001, 32'h0000_0001, 32'h8000_0000}, // R6
        {4'd6,  1'b1, 10'd5,   32'h0000_0100, 32'h0000_0001, 32'h0000_0000, 32'h0000_0000}, // R6
        {4'd6,  1'b1, 10'd4,   32'h0000_0000, 32'h0000_0001, 32'h0000_0001, 32'h0000_0000}, // R6
        {4'd8,  1'b1, 10'd8,   32'hFFFF_FFFF, 32'h0060_0000, 32'h0000_0000, 32'h0060_0000}, // R8 R7
        {4'd7,  1'b0, 10'd8,   32'h0000_0000, 32'h4060_0000, 32'h7FE0_0000, 32'h4060_0000}, // R7 R8
        {4'd9,  1'b1, 10'd9,   32'h0020_0000, 32'h4060_0000, 32'h0000_0000, 32'h4040_0000}, // R9
        {4'd11, 1'b1, 10'd6,   32'hFFFF_FFFF, 32'h4040_0000, 32'h0000_0000, 32'h4040_0000}, // R11
        {4'd10, 1'b0, 10'd2,   32'h0000_0000, 32'h0010_0020, 32'h0000_0020, 32'h8000_0000}, // R10
        {4'd11, 1'b0, 10'h3FF, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000}  // R11
    };

    initial begin
        // R12: state held in reset
        repeat (3) @(negedge clk);
        chk("R12", "irq_out in reset", irq_out, 32'h0);
        chk("R12", "rdata in reset", bus_rdata, 32'h0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            string tag;
            tag = $sformatf("R%0d step %0d", VEC[k][142:139], k);
            bus_we        = VEC[k][138];
            bus_word_addr = VEC[k][137:128];
            bus_wdata     = VEC[k][127:96];
            irq_in        = VEC[k][95:64];
            @(negedge clk);
            chk(tag, "rdata", bus_rdata, VEC[k][63:32]);
            chk(tag, "irq_out", irq_out, VEC[k][31:0]);
        end

        // State now: mask 0x20, pass-through 0x7FC0_0000, raw 0
        // R13: no same-cycle response, one edge of latency
        bus_we = 1'b0;
        bus_word_addr = 10'd0;
        irq_in = 32'h0000_0020;
        #1;
        chk("R13", "irq_out before edge", irq_out, 32'h0);
        @(negedge clk);
        chk("R13", "irq_out after one edge", irq_out, 32'h8000_0000);
        chk("R13", "status from old raw", bus_rdata, 32'h0);
        @(negedge clk);
        chk("R13", "status after raw update", bus_rdata, 32'h0000_0020);

        // R6: soft read exposes bit 0 only
        bus_word_addr = 10'd4;
        irq_in = 32'hFFFF_FFFE;
        repeat (2) @(negedge clk);
        chk("R6", "soft read bit0 low", bus_rdata, 32'h0);
        irq_in = 32'hFFFF_FFFF;
        repeat (2) @(negedge clk);
        chk("R6", "soft read bit0 high", bus_rdata, 32'h1);

        // R12: reset in mid-run with all inputs high
        bus_we = 1'b1;
        bus_word_addr = 10'd8;
        bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_we = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R12", "irq_out at reset", irq_out, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        bus_word_addr = 10'd2;
        @(negedge clk);
        chk("R12", "mask after reset", bus_rdata, 32'h0);
        chk("R12", "irq_out after reset", irq_out, 32'h0);
        bus_word_addr = 10'd8;
        @(negedge clk);
        chk("R12", "pass-through after reset", bus_rdata, 32'h0);
        chk("R12", "irq_out still low", irq_out, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule